// File: doc/BRIEF.md
# Banknote-to-Coin Payout Controller

This block is a synchronous controller for a change machine that takes one banknote at a time and pays it out as a fixed number of coins. The note acceptor in front of it raises a presence strobe and a validity flag. The controller sets a reject line when the note is bad. When the note is good, it emits a counted burst of single-cycle pulses on a coin-eject line, one pulse per coin.

A small control state machine sequences the transaction. A datapath counter, which is cleared at the start of each payout, keeps track of how many coins have gone out. Each state's register transfers take effect together on one clock edge. After a rejected note or a completed payout, the controller always returns to its wait state. The presence strobe is sampled once per clock, and only in the wait state. A strobe that is still high when the controller returns to the wait state starts another transaction.

Reset is asynchronous and active low. Its release is synchronised to the clock inside the block.

Top module: `coin_dispense_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no note offered, `eject_o` and `reject_o` are both 0.
- R2: While `note_present_i` is 0 in the wait state, no eject pulse and no reject pulse occur.
- R3: A note sampled with `note_valid_i`=0 raises `reject_o` for exactly one cycle, produces no eject pulse, and returns the controller to the wait state. A strobe held for L cycles yields ceil(L/2) reject pulses.
- R4: A note sampled with `note_valid_i`=1 produces exactly COIN_COUNT eject pulses (10 by default) and no reject pulse.
- R5: Each eject pulse is high for one cycle, and consecutive pulses within a burst are separated by exactly one low cycle.
- R6: If a valid note is sampled at clock edge E0, `eject_o` is low after E0, high after E1, and low again after E2.
- R7: A valid transaction occupies 22 cycles, from one wait-state sample to the next. A valid strobe held for L cycles yields ceil(L/22) complete bursts.
- R8: During a payout, `note_present_i` and `note_valid_i` are ignored. Toggling them does not change the pulse count and raises no reject.
- R9: `eject_o` and `reject_o` are never high in the same cycle.
- R10: Asserting `rst_n_i` in the middle of a payout drives both outputs low at once. No further pulses occur until a new note is sampled after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| note_present_i | input | 1 | Banknote presence strobe, sampled in the wait state |
| note_valid_i | input | 1 | Validity flag for the offered note |
| reject_o | output | 1 | One-cycle reject indication for an invalid note |
| eject_o | output | 1 | Coin-eject pulse line, one pulse per coin |

## Verification
Any corruption of the state register or the coin counter appears at the ports within one payout.

- An off-by-one in the counter compare changes the burst length, so a burst has nine or eleven pulses instead of ten.
- A wrong transition stretches a pulse or merges two pulses, or lets a reject overlap an eject. Either is visible within two cycles.
- A state that fails to return to the wait state shows up on the next note: its burst is missing, or it starts at the wrong cycle.

The bench sweeps strobe lengths for both validity values and predicts the pulse counts arithmetically from the 2-cycle reject period and the 22-cycle payout period.

// File: rtl/coin_dispense_pkg.sv
package coin_dispense_pkg;

  typedef enum logic [2:0] {
    ST_INIT     = 3'd0,
    ST_WAIT     = 3'd1,
    ST_REJECT   = 3'd2,
    ST_CLEAR    = 3'd3,
    ST_EJECT_HI = 3'd4,
    ST_EJECT_LO = 3'd5
  } cd_state_t;

endpackage

// File: rtl/cd_reset_sync.sv
module cd_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_sync_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/cd_payout_counter.sv
module cd_payout_counter #(
  parameter int COIN_COUNT = 10,
  parameter int CNT_W      = $clog2(COIN_COUNT + 1)
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(COIN_COUNT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Clear has priority; the enable covers both transfers.
  assign cnt_en = clr_i | inc_i;

  always_comb begin
    if (clr_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // Compare uses the count before this cycle's increment.
  assign last_o = (cnt_q == LAST_VAL);

endmodule

// File: rtl/cd_ctrl_fsm.sv
module cd_ctrl_fsm
  import coin_dispense_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic note_present_i,
  input  logic note_valid_i,
  input  logic last_coin_i,
  output logic cnt_clr_o,
  output logic cnt_inc_o,
  output logic reject_o,
  output logic eject_o
);

  cd_state_t state_q;
  cd_state_t state_d;
  logic      reject_q;
  logic      eject_q;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_INIT:     state_d = ST_WAIT;
      ST_WAIT: begin
        if (note_present_i) begin
          state_d = note_valid_i ? ST_CLEAR : ST_REJECT;
        end
      end
      ST_REJECT:   state_d = ST_WAIT;
      ST_CLEAR:    state_d = ST_EJECT_HI;
      ST_EJECT_HI: state_d = ST_EJECT_LO;
      ST_EJECT_LO: state_d = last_coin_i ? ST_WAIT : ST_EJECT_HI;
      default:     state_d = ST_INIT;
    endcase
  end

  assign cnt_clr_o = (state_q == ST_CLEAR);
  assign cnt_inc_o = (state_q == ST_EJECT_LO);

  // State and output registers
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q  <= ST_INIT;
      reject_q <= 1'b0;
      eject_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      reject_q <= (state_d == ST_REJECT);
      eject_q  <= (state_d == ST_EJECT_HI);
    end
  end

  assign reject_o = reject_q;
  assign eject_o  = eject_q;

endmodule

// File: rtl/coin_dispense_ctrl.sv
module coin_dispense_ctrl #(
  parameter int COIN_COUNT  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic note_present_i,
  input  logic note_valid_i,
  output logic reject_o,
  output logic eject_o
);

  localparam int CNT_W = $clog2(COIN_COUNT + 1);

  logic rst_sync_n;
  logic cnt_clr;
  logic cnt_inc;
  logic last_coin;

  cd_reset_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .rst_sync_n_o (rst_sync_n)
  );

  cd_payout_counter #(
    .COIN_COUNT (COIN_COUNT),
    .CNT_W      (CNT_W)
  ) u_counter (
    .clk_i   (clk_i),
    .rst_n_i (rst_sync_n),
    .clr_i   (cnt_clr),
    .inc_i   (cnt_inc),
    .last_o  (last_coin)
  );

  cd_ctrl_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_n_i        (rst_sync_n),
    .note_present_i (note_present_i),
    .note_valid_i   (note_valid_i),
    .last_coin_i    (last_coin),
    .cnt_clr_o      (cnt_clr),
    .cnt_inc_o      (cnt_inc),
    .reject_o       (reject_o),
    .eject_o        (eject_o)
  );

endmodule

// File: rtl/coin_dispense_ctrl_chk.sv
module coin_dispense_ctrl_chk #(
  parameter int COIN_COUNT = 10
) (
  input logic clk_i,
  input logic rst_n_i,
  input logic note_present_i,
  input logic note_valid_i,
  input logic reject_o,
  input logic eject_o
);

  localparam int BW = $clog2(COIN_COUNT + 2) + 1;

  logic [BW-1:0] burst_cnt_q;
  logic          eject_d1_q;
  logic          low2;

  assign low2 = !eject_o && !eject_d1_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      burst_cnt_q <= '0;
      eject_d1_q  <= 1'b0;
    end else begin
      eject_d1_q <= eject_o;
      if (low2) begin
        burst_cnt_q <= '0;
      end else if (eject_o && !eject_d1_q) begin
        burst_cnt_q <= burst_cnt_q + BW'(1);
      end
    end
  end

  // R10 / R1: outputs held low while reset is asserted
  a_r10_reset_quiet: assert property (@(posedge clk_i)
    !rst_n_i |-> (!eject_o && !reject_o));

  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !(eject_o && reject_o));

  a_r5_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    eject_o |=> !eject_o);

  a_r3_reject_single: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    reject_o |=> !reject_o);

  a_r3_reject_cause: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(reject_o) |-> $past(note_present_i && !note_valid_i));

  a_r4_burst_bound: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    burst_cnt_q <= BW'(COIN_COUNT));

endmodule

bind coin_dispense_ctrl coin_dispense_ctrl_chk #(
  .COIN_COUNT (COIN_COUNT)
) u_chk (
  .clk_i          (clk_i),
  .rst_n_i        (rst_n_i),
  .note_present_i (note_present_i),
  .note_valid_i   (note_valid_i),
  .reject_o       (reject_o),
  .eject_o        (eject_o)
);

// File: tb/coin_dispense_ctrl_tb_top.sv
module coin_dispense_ctrl_tb_top;

  localparam int COINS  = 10;
  localparam int PERIOD = 2 * COINS + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic note = 1'b0;
  logic valid = 1'b0;
  logic reject;
  logic eject;

  int checks = 0;
  int fails = 0;
  int ej_rises = 0;
  int rj_rises = 0;
  int max_hi = 0;
  int min_gap = 1000;
  int hi_run = 0;
  int lo_run = 0;
  int burst_len = 0;
  logic prev_ej = 1'b0;
  logic prev_rj = 1'b0;
  logic overlap = 1'b0;

  always #5 clk = ~clk;

  coin_dispense_ctrl #(.COIN_COUNT(COINS)) dut_i (
    .clk_i          (clk),
    .rst_n_i        (rst_n),
    .note_present_i (note),
    .note_valid_i   (valid),
    .reject_o       (reject),
    .eject_o        (eject)
  );

  // Port monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (eject && reject) overlap = 1'b1;
    if (eject && !prev_ej) begin
      ej_rises++;
      if (lo_run < min_gap) min_gap = lo_run;
    end
    if (reject && !prev_rj) rj_rises++;
    if (eject) begin
      hi_run++;
      if (hi_run > max_hi) max_hi = hi_run;
      lo_run = 0;
    end else begin
      hi_run = 0;
      lo_run++;
    end
    prev_ej = eject;
    prev_rj = reject;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    ej_rises = 0;
    rj_rises = 0;
    max_hi = 0;
    min_gap = 1000;
    overlap = 1'b0;
  endtask

  task automatic offer(input int len, input logic v);
    @(negedge clk);
    clear_mon();
    note = 1'b1;
    valid = v;
    repeat (len) @(negedge clk);
    note = 1'b0;
    valid = 1'b0;
    repeat (PERIOD + 8) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 eject in reset", int'(eject), 0);
    check("R1 reject in reset", int'(reject), 0);
    rst_n = 1'b1;
    clear_mon();
    repeat (10) @(negedge clk);
    // R2: idle, no note
    check("R1 eject after release", int'(eject), 0);
    check("R2 idle eject pulses", ej_rises, 0);
    check("R2 idle reject pulses", rj_rises, 0);

    // R3 sweep: invalid strobe lengths
    for (int len = 1; len <= 6; len++) begin
      offer(len, 1'b0);
      check("R3 reject count", rj_rises, (len + 1) / 2);
      check("R3 no eject on invalid", ej_rises, 0);
      check("R3 reject width", int'(reject), 0);
    end

    // R4/R5/R7 sweep: valid strobe lengths
    begin
      int lens [7] = '{1, 2, 21, 22, 23, 44, 45};
      foreach (lens[i]) begin
        offer(lens[i], 1'b1);
        check("R7 pulses for held strobe", ej_rises,
              COINS * ((lens[i] + PERIOD - 1) / PERIOD));
        check("R4 no reject on valid", rj_rises, 0);
        check("R5 pulse width", max_hi, 1);
        check("R5 inter-pulse gap", min_gap, 1);
        check("R9 no overlap", int'(overlap), 0);
      end
    end
    offer(1, 1'b1);
    check("R4 single note pulse count", ej_rises, COINS);

    // R6: first pulse timing
    @(negedge clk);
    note = 1'b1;
    valid = 1'b1;
    @(negedge clk);               // E0 passed
    note = 1'b0;
    valid = 1'b0;
    check("R6 eject after E0", int'(eject), 0);
    @(negedge clk);
    check("R6 eject after E1", int'(eject), 1);
    @(negedge clk);
    check("R6 eject after E2", int'(eject), 0);
    repeat (PERIOD + 4) @(negedge clk);

    // R8: inputs ignored during payout
    @(negedge clk);
    clear_mon();
    note = 1'b1;
    valid = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 2 * COINS - 2; k++) begin
      note = k[0];
      valid = 1'b0;
      @(negedge clk);
    end
    note = 1'b0;
    repeat (PERIOD + 6) @(negedge clk);
    check("R8 pulse count with noise", ej_rises, COINS);
    check("R8 no reject during payout", rj_rises, 0);

    // R10: reset mid-burst
    @(negedge clk);
    note = 1'b1;
    valid = 1'b1;
    @(negedge clk);
    note = 1'b0;
    valid = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 eject cleared by reset", int'(eject), 0);
    check("R10 reject cleared by reset", int'(reject), 0);
    @(negedge clk);
    rst_n = 1'b1;
    clear_mon();
    repeat (PERIOD + 10) @(negedge clk);
    check("R10 no pulses after reset", ej_rises, 0);
    offer(1, 1'b1);
    check("R10 full burst after reset", ej_rises, COINS);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule